// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the byte-wide register face of a classic serial port. A host reaches eight register offsets through a simple bus: select, write enable, address, write data and combinational read data. Received bytes arrive on a valid/ready stream. Bytes written to the transmit register leave on a stream that has no back-pressure. The block keeps the interrupt-enable, line-control and modem-control state, and it works out the interrupt-identification reply. It drives a single interrupt line.

Neither interrupt source posts at once. Each one has its own restartable delay timer of `DELAY` clock cycles, which an enable write, a transmit write or a receive read can start again. There is one exception. When a new byte appears while the receive path is idle and receive interrupts are enabled, the receive interrupt posts immediately. Divisor-latch accesses are accepted and discarded, because no baud generator sits behind this front end.

Top module: `uart_irq_regs`

## Requirements
- R1: An access with an address of 8 or higher drives `bus_err` high in the access cycle, reads as 0 and changes no state.
- R2: While line-control bit 7 is set, offsets 0 and 1 are divisor accesses. Reads of either offset return 0 and consume no received byte. Writes neither emit a byte nor change the enable register.
- R3: A read of offset 0 returns `rx_data` and completes the handshake (`rx_ready` high) if `rx_valid` is high, and returns 0 otherwise. The read clears a pending receive interrupt and drops `irq`.
- R4: A write to offset 0 drives `tx_valid` with `tx_data` equal to the written byte in the same cycle. It clears a pending transmit interrupt and drops `irq`, and it restarts the transmit timer when enable bit 1 is set.
- R5: An armed timer makes its source pending and raises `irq` on the `DELAY`-th clock edge after the arming edge. Arming a timer that is already running restarts the full interval.
- R6: A write to offset 1 stores the enable byte. With bit 1 set it arms the transmit timer; with bit 1 clear it cancels that timer and clears a pending transmit interrupt. With bit 0 set and `rx_valid` high it arms the receive timer; otherwise it cancels that timer and clears a pending receive interrupt. In either cancel case `irq` drops if an interrupt was pending.
- R7: A read of offset 2 returns 0x04 when a receive interrupt is pending, else 0x02 when a transmit interrupt is pending, else 0x01. Every such read clears the pending transmit interrupt and leaves `irq` unchanged.
- R8: Offset 5 reads 0x60 ORed with `rx_valid` in bit 0. Offsets 6 and 7 always read 0, and writes to offset 7 are discarded.
- R9: A write of 0x1A to offset 4 stores 0x9A, which offset 4 reads back. Any other value written there is ignored.
- R10: When `rx_valid` rises while enable bit 0 is set and the receive timer is idle, the receive interrupt becomes pending and `irq` rises on that same clock edge.
- R11: On the cycle after a data read, the receive timer is armed if `rx_valid` is still high and enable bit 0 is set.
- R12: After reset the enable, line-control and modem-control registers read 0, `irq` is low and offset 2 reads 0x01.
- R13: Offset 3 stores all eight written bits and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| bus_err | output | 1 | Access outside offsets 0..7 |
| rx_valid | input | 1 | Received byte waiting |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Received byte taken this cycle |
| tx_valid | output | 1 | Transmit byte emitted this cycle |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps every line-control and modem-control value and every offset from 0 to 15. A design that decodes the loopback pattern too loosely, or that lets out-of-range writes alias into the map, shows up in those sweeps. The timer checks sample one edge before and one edge at the expected expiry, both after a first arming and after a restart in mid-interval, so an off-by-one delay or a restart that fails to reload the full count gets caught. Identification reads are made with both sources pending, which exposes a wrong priority order or a read that does not clear the transmit interrupt. Receive reads are made with data still waiting and with the stream drained, so that a missing or spurious re-arm after a read is reported.

// File: rtl/uart_irq_regs.sv
module uart_irq_regs #(
  parameter int DELAY = 450,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          bus_err,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          irq
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] FULL = CW'(DELAY);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [2:0] OFS_DATA = 3'd0, OFS_IEN = 3'd1, OFS_IID = 3'd2, OFS_LCTL = 3'd3;
  localparam logic [2:0] OFS_MCTL = 3'd4, OFS_LSTS = 3'd5, OFS_MSTS = 3'd6, OFS_SCR = 3'd7;
  localparam logic [7:0] LOOP_MATCH = 8'h1A;
  localparam logic [7:0] LOOP_STORE = 8'h9A;

  logic [7:0]    ier, lcr, mcr;
  logic          pend_rx, pend_tx;
  logic [CW-1:0] tmr_rx, tmr_tx;
  logic          rx_seen, rd_q;

  wire       in_map = (bus_addr[AW-1:3] == '0);
  wire [2:0] off    = bus_addr[2:0];
  wire       dlab   = lcr[7];
  wire       rd     = bus_sel & ~bus_we & in_map;
  wire       wr     = bus_sel &  bus_we & in_map;

  wire data_rd = rd & (off == OFS_DATA) & ~dlab;
  wire data_wr = wr & (off == OFS_DATA) & ~dlab;
  wire ier_wr  = wr & (off == OFS_IEN)  & ~dlab;
  wire iid_rd  = rd & (off == OFS_IID);
  wire lcr_wr  = wr & (off == OFS_LCTL);
  wire mcr_wr  = wr & (off == OFS_MCTL);

  wire exp_rx  = (tmr_rx == ONE);
  wire exp_tx  = (tmr_tx == ONE);
  wire arrive  = rx_valid & ~rx_seen & ier[0] & (tmr_rx == '0);
  wire post_rx = (exp_rx & ier[0]) | arrive;
  wire post_tx = exp_tx & ier[1];

  assign bus_err  = bus_sel & ~in_map;
  assign rx_ready = data_rd & rx_valid;
  assign tx_valid = data_wr;
  assign tx_data  = bus_wdata;

  always_comb begin
    bus_rdata = 8'h00;
    if (rd) begin
      case (off)
        OFS_DATA: bus_rdata = (!dlab && rx_valid) ? rx_data : 8'h00;
        OFS_IEN:  bus_rdata = dlab ? 8'h00 : ier;
        OFS_IID:  bus_rdata = pend_rx ? 8'h04 : (pend_tx ? 8'h02 : 8'h01);
        OFS_LCTL: bus_rdata = lcr;
        OFS_MCTL: bus_rdata = mcr;
        OFS_LSTS: bus_rdata = {1'b0, 2'b11, 4'b0000, rx_valid};
        OFS_MSTS: bus_rdata = 8'h00;
        OFS_SCR:  bus_rdata = 8'h00;
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier     <= '0;
      lcr     <= '0;
      mcr     <= '0;
      pend_rx <= 1'b0;
      pend_tx <= 1'b0;
      tmr_rx  <= '0;
      tmr_tx  <= '0;
      rx_seen <= 1'b0;
      rd_q    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rx_seen <= rx_valid;
      rd_q    <= data_rd;
      if (tmr_rx != '0) tmr_rx <= tmr_rx - ONE;
      if (tmr_tx != '0) tmr_tx <= tmr_tx - ONE;

      if (post_rx) begin
        pend_rx <= 1'b1;
        irq     <= 1'b1;
      end
      if (post_tx) begin
        pend_tx <= 1'b1;
        irq     <= 1'b1;
      end
      if (rd_q && rx_valid && ier[0]) tmr_rx <= FULL;

      if (data_rd) begin
        pend_rx <= 1'b0;
        irq     <= 1'b0;
      end
      if (data_wr) begin
        pend_tx <= 1'b0;
        irq     <= 1'b0;
        if (ier[1]) tmr_tx <= FULL;
      end
      if (ier_wr) begin
        ier <= bus_wdata;
        if (bus_wdata[1]) tmr_tx <= FULL;
        else begin
          tmr_tx  <= '0;
          pend_tx <= 1'b0;
          if (pend_tx || post_tx) irq <= 1'b0;
        end
        if (bus_wdata[0] && rx_valid) tmr_rx <= FULL;
        else begin
          tmr_rx  <= '0;
          pend_rx <= 1'b0;
          if (pend_rx || post_rx) irq <= 1'b0;
        end
      end
      if (iid_rd) pend_tx <= 1'b0;
      if (lcr_wr) lcr <= bus_wdata;
      if (mcr_wr && bus_wdata == LOOP_MATCH) mcr <= LOOP_STORE;
    end
  end
endmodule

// File: rtl/uart_irq_regs_chk.sv
module uart_irq_regs_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_rdata,
  input logic          bus_err,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic          irq,
  input logic          pend_rx,
  input logic          pend_tx,
  input logic [7:0]    ier
);
  wire iid_read = bus_sel && !bus_we && bus_addr == AW'(2);
  wire lsr_read = bus_sel && !bus_we && bus_addr == AW'(5);

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !bus_we) |-> bus_rdata == 8'h00); // R1
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> (!pend_rx && !irq)); // R3
  AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> (!pend_tx && !irq)); // R4
  AST_TX_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_tx) |-> $past(ier[1])); // R5
  AST_IID_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_read && pend_rx) |-> bus_rdata == 8'h04); // R7
  AST_IID_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    iid_read |=> !pend_tx); // R7
  AST_LSR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_read |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == rx_valid)); // R8
endmodule

bind uart_irq_regs uart_irq_regs_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_uart_irq_regs.sv
module tb_uart_irq_regs;
  localparam int DLY = 12;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0, bus_rdata;
  logic          bus_err, rx_ready, tx_valid, irq;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0, tx_data;

  int checks = 0, errors = 0;
  logic [7:0] r_data;
  logic       r_err, r_rdy, r_txv;
  logic [7:0] r_txd;

  always #10 clk = ~clk;

  uart_irq_regs #(.DELAY(DLY), .AW(AW)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input int addr, input logic [7:0] wd);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = AW'(addr); bus_wdata = wd;
    #1;
    r_data = bus_rdata; r_err = bus_err; r_rdy = rx_ready; r_txv = tx_valid; r_txd = tx_data;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);

    chk("R12 irq after reset", int'(irq), 0);
    for (int a = 0; a < 16; a++) begin
      access(1'b0, a, 8'h00);
      chk("R1 err flag", int'(r_err), (a >= 8) ? 1 : 0);
      chk(a == 2 ? "R12 idle id code" : (a == 5 ? "R8 line status" : "R12 reset read"),
          int'(r_data), (a == 2) ? 8'h01 : ((a == 5) ? 8'h60 : 8'h00));
    end

    for (int v = 0; v < 256; v++) begin
      access(1'b1, 3, 8'(v));
      access(1'b0, 3, 8'h00);
      chk("R13 line control readback", int'(r_data), v);
    end
    access(1'b1, 3, 8'h00);

    for (int v = 0; v < 256; v++) begin
      access(1'b1, 4, 8'(v));
      access(1'b0, 4, 8'h00);
      chk("R9 modem control", int'(r_data), (v >= 8'h1A) ? 8'h9A : 8'h00);
    end

    access(1'b1, 7, 8'hFF);
    access(1'b0, 7, 8'h00);
    chk("R8 scratch reads zero", int'(r_data), 0);
    for (int a = 8; a < 16; a++) begin
      access(1'b1, a, 8'h83);
      chk("R1 write err flag", int'(r_err), 1);
      chk("R1 write emits nothing", int'(r_txv), 0);
    end
    access(1'b0, 3, 8'h00);
    chk("R1 line control untouched", int'(r_data), 0);
    access(1'b0, 1, 8'h00);
    chk("R1 enable untouched", int'(r_data), 0);

    access(1'b1, 0, 8'h55);
    chk("R4 tx valid", int'(r_txv), 1);
    chk("R4 tx data", int'(r_txd), 8'h55);
    edges(20);
    chk("R4 no irq with tx disabled", int'(irq), 0);

    access(1'b1, 1, 8'h02);
    edges(DLY - 1);
    chk("R5 irq before expiry", int'(irq), 0);
    edges(1);
    chk("R5 irq at expiry", int'(irq), 1);
    access(1'b0, 2, 8'h00);
    chk("R7 tx id code", int'(r_data), 8'h02);
    access(1'b0, 2, 8'h00);
    chk("R7 id read cleared tx", int'(r_data), 8'h01);
    chk("R7 irq unchanged by id read", int'(irq), 1);
    access(1'b1, 0, 8'h10);
    chk("R4 write drops irq", int'(irq), 0);
    edges(6);
    access(1'b1, 0, 8'h11);
    edges(DLY - 1);
    chk("R5 restart holds off irq", int'(irq), 0);
    edges(1);
    chk("R5 restart expiry", int'(irq), 1);

    access(1'b1, 1, 8'h00);
    chk("R6 disable drops irq", int'(irq), 0);
    access(1'b1, 1, 8'h02);
    edges(5);
    access(1'b1, 1, 8'h00);
    edges(20);
    chk("R6 cancelled timer", int'(irq), 0);
    access(1'b0, 2, 8'h00);
    chk("R6 nothing pending", int'(r_data), 8'h01);

    access(1'b1, 3, 8'h80);
    access(1'b1, 1, 8'h03);
    access(1'b1, 0, 8'h77);
    chk("R2 divisor write emits nothing", int'(r_txv), 0);
    rx_valid = 1'b1; rx_data = 8'h11;
    access(1'b0, 0, 8'h00);
    chk("R2 divisor read value", int'(r_data), 0);
    chk("R2 divisor read takes no byte", int'(r_rdy), 0);
    access(1'b0, 1, 8'h00);
    chk("R2 divisor high read", int'(r_data), 0);
    access(1'b1, 3, 8'h00);
    access(1'b0, 1, 8'h00);
    chk("R2 enable kept", int'(r_data), 0);
    access(1'b0, 5, 8'h00);
    chk("R8 data ready", int'(r_data), 8'h61);
    chk("R10 no post when disabled", int'(irq), 0);

    rx_data = 8'h5A;
    access(1'b1, 1, 8'h01);
    edges(DLY - 1);
    chk("R6 rx timer pending", int'(irq), 0);
    edges(1);
    chk("R6 rx timer expiry", int'(irq), 1);
    access(1'b0, 2, 8'h00);
    chk("R7 rx id code", int'(r_data), 8'h04);
    access(1'b0, 0, 8'h00);
    chk("R3 read data", int'(r_data), 8'h5A);
    chk("R3 handshake", int'(r_rdy), 1);
    rx_valid = 1'b0;
    chk("R3 read drops irq", int'(irq), 0);
    edges(20);
    chk("R11 no rearm when drained", int'(irq), 0);
    access(1'b0, 0, 8'h00);
    chk("R3 empty read value", int'(r_data), 0);
    chk("R3 empty read no handshake", int'(r_rdy), 0);

    access(1'b1, 1, 8'h03);
    edges(DLY);
    chk("R5 tx post with both enabled", int'(irq), 1);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hA5;
    edges(1);
    access(1'b0, 2, 8'h00);
    chk("R10 immediate rx post", int'(r_data), 8'h04);
    access(1'b0, 2, 8'h00);
    chk("R7 rx still first", int'(r_data), 8'h04);
    access(1'b0, 0, 8'h00);
    chk("R3 read arrived byte", int'(r_data), 8'hA5);
    rx_data = 8'h3C;
    edges(DLY);
    chk("R11 rearm holds off", int'(irq), 0);
    edges(1);
    chk("R11 rearm expiry", int'(irq), 1);
    access(1'b0, 2, 8'h00);
    chk("R11 rx pending again", int'(r_data), 8'h04);
    access(1'b0, 0, 8'h00);
    chk("R3 second byte", int'(r_data), 8'h3C);
    rx_valid = 1'b0;
    access(1'b0, 1, 8'h00);
    chk("R6 enable readback", int'(r_data), 8'h03);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule